// File: doc/BRIEF.md
# Multithreaded Scalar Register Unit

This block holds a register file split into three thread banks of 64 registers, each 32 bits wide, together with a scalar execution engine. The engine runs one instruction at a time. It supports four operations: loading a 16-bit half of a register from an immediate, a 32-bit add, a 16x16 unsigned multiply with a 32-bit product, and a no-op. Each instruction arrives as a 32-bit word with a thread tag, and it can only read and write the bank of its own thread. While an instruction is in flight the engine raises `busy`, so that neighbouring units can hold off until the registers they consume have settled.

A host port reaches every register of every bank by byte address. Writes take effect at the clock edge. Read data comes back from a register one cycle later. Firmware typically sets constants through this port or through half-register loads, then derives addresses and sizes with add and multiply before downstream configuration logic copies them out.

Top module: `sgpr_exec_unit`

## Requirements
- R1: After reset, `busy` and `err_pulse` are 0, `ins_ready` is 1, and every register of every bank reads 0.
- R2: Opcode `ins_word[31:24]` = 0x45 with bit 7 = 0 loads a half register. Bits [6:0] are a half index h, and bits [21:8] are a 14-bit immediate, zero-extended to 16 bits. An even h writes the low 16 bits of register h/2 and an odd h writes its high 16 bits. The other half keeps its value. This operation holds `busy` for 1 cycle.
- R3: Opcode 0x58 writes A + B, wrapped to 32 bits, into the register at bits [17:12]. A is the register at bits [5:0]. When bit 23 is 0, B is the register at bits [11:6]; when bit 23 is 1, B is the 6-bit unsigned constant in bits [11:6].
- R4: Opcode 0x5A uses the same fields as R3. It writes the 32-bit unsigned product of the low 16 bits of A and the low 16 bits of B.
- R5: An add or multiply holds `busy` for 3 cycles when B is a constant, or when the result, A and B indices all share bits [5:2]. In every other case it holds `busy` for 4 cycles.
- R6: Opcode 0x60 is a no-op. It holds `busy` for 1 cycle and changes no register.
- R7: `ins_ready` is 1 when the unit is idle or in the final busy cycle of an instruction, and 0 at all other times. `busy` stays high without a gap across back-to-back instructions.
- R8: Thread tags 0, 1 and 2 select the bank. An instruction reads and writes only the bank of its own tag.
- R9: The host byte address is thread x 256 + register x 4, and address bits [1:0] are ignored. A host write lands at the edge where `host_we` is sampled. `host_rdata` shows the register addressed at the previous edge. Addresses with thread field 3 read as 0, and writes to them are dropped.
- R10: The unit accepts the following instructions but does not execute them: an unknown opcode, opcode 0x45 with bit 7 = 1, and any instruction with thread tag 3. Such an instruction changes no register and does not raise `busy`. It pulses `err_pulse` for exactly one cycle, in the cycle after it is accepted.
- R11: When an instruction result and a host write target the same register at the same edge, the instruction result is kept and the whole host write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction offered |
| ins_ready | output | 1 | Instruction can be accepted this cycle |
| ins_word | input | 32 | Instruction word |
| ins_tid | input | 2 | Thread tag of the instruction |
| busy | output | 1 | An instruction is executing |
| err_pulse | output | 1 | One-cycle pulse for a rejected instruction |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 10 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, registered |

## Verification
If an instruction is accepted at edge E, its result is written at edge E+L, where L is 1, 3 or 4 depending on the operation. `busy` reads high for exactly L falling-edge samples after E. The bench therefore counts those samples as the measured latency, and it reads the result through the host port only after `busy` has dropped. A rejected instruction shows `err_pulse` at the first falling edge after acceptance and not at the next one. Host reads are sampled one full cycle after the address is applied. In the collision test, the host write is placed on exactly the edge at which a one-cycle load retires.

// File: rtl/sgpr_pkg.sv
package sgpr_pkg;

    localparam int INSN_W = 32;
    localparam int FLD_W  = 6;
    localparam int IMM_W  = 14;
    localparam int HIDX_W = 7;
    localparam int LAT_W  = 3;

    localparam logic [7:0] OPC_HALF = 8'h45;
    localparam logic [7:0] OPC_ADD  = 8'h58;
    localparam logic [7:0] OPC_MUL  = 8'h5A;
    localparam logic [7:0] OPC_NOP  = 8'h60;

    localparam logic [LAT_W-1:0] LAT_ONE   = 3'd1;
    localparam logic [LAT_W-1:0] LAT_FAST  = 3'd3;
    localparam logic [LAT_W-1:0] LAT_SLOW  = 3'd4;

    typedef enum logic [2:0] {
        OP_NOP,
        OP_HALF,
        OP_ADD,
        OP_MUL,
        OP_BAD
    } sgpr_op_e;

    typedef struct packed {
        sgpr_op_e           op;
        logic               b_imm;
        logic [FLD_W-1:0]   rd;
        logic [FLD_W-1:0]   rb;
        logic [FLD_W-1:0]   ra;
        logic [IMM_W-1:0]   imm;
        logic [HIDX_W-1:0]  hidx;
        logic [LAT_W-1:0]   lat;
    } sgpr_dec_t;

endpackage

// File: rtl/sgpr_decode.sv
module sgpr_decode
    import sgpr_pkg::*;
(
    input  logic [INSN_W-1:0] word,
    output sgpr_dec_t         dec
);

    localparam int GRP_LSB = 2;

    logic same_grp;
    logic unused_bits;

    assign unused_bits = ^word[22:18];

    always_comb begin
        same_grp = (word[5:GRP_LSB]   == word[17:12+GRP_LSB]) &&
                   (word[11:6+GRP_LSB] == word[17:12+GRP_LSB]);

        dec       = '0;
        dec.op    = OP_BAD;
        dec.b_imm = word[23];
        dec.rd    = word[17:12];
        dec.rb    = word[11:6];
        dec.ra    = word[5:0];
        dec.imm   = word[21:8];
        dec.hidx  = word[6:0];
        dec.lat   = LAT_ONE;

        case (word[31:24])
            OPC_HALF: dec.op = word[7] ? OP_BAD : OP_HALF;
            OPC_NOP:  dec.op = OP_NOP;
            OPC_ADD, OPC_MUL: begin
                dec.op  = (word[31:24] == OPC_ADD) ? OP_ADD : OP_MUL;
                dec.lat = (word[23] || same_grp) ? LAT_FAST : LAT_SLOW;
            end
            default:  dec.op = OP_BAD;
        endcase
    end

    always_comb begin
        if (dec.op == OP_ADD || dec.op == OP_MUL) begin
            AST_ARITH_LAT: assert (dec.lat == LAT_FAST || dec.lat == LAT_SLOW); // R5
        end
    end

endmodule

// File: rtl/sgpr_alu.sv
module sgpr_alu
    import sgpr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  sgpr_op_e          op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] res
);

    localparam int HALF_W = DATA_W / 2;

    always_comb begin
        case (op)
            OP_ADD:  res = opa + opb;
            OP_MUL:  res = DATA_W'(opa[HALF_W-1:0]) * DATA_W'(opb[HALF_W-1:0]);
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/sgpr_regfile.sv
module sgpr_regfile #(
    parameter int NUM_THREADS = 3,
    parameter int NUM_REGS    = 64,
    parameter int DATA_W      = 32,
    parameter int IDX_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  ra_idx,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [DATA_W-1:0] ra_data,
    output logic [DATA_W-1:0] rb_data,
    input  logic              ins_we,
    input  logic [IDX_W-1:0]  ins_idx,
    input  logic [1:0]        ins_hen,
    input  logic [DATA_W-1:0] ins_wdata,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd_ok,
    output logic [DATA_W-1:0] host_rdata
);

    localparam int ENTRIES = NUM_THREADS * NUM_REGS;
    localparam int HALF_W  = DATA_W / 2;

    logic [DATA_W-1:0] mem_q [ENTRIES];
    logic [DATA_W-1:0] mem_d [ENTRIES];
    logic [DATA_W-1:0] rd_q;
    logic [DATA_W-1:0] rd_d;
    logic              clash;

    assign ra_data    = mem_q[ra_idx];
    assign rb_data    = mem_q[rb_idx];
    assign host_rdata = rd_q;

    always_comb begin
        mem_d = mem_q;
        clash = ins_we && host_we && (ins_idx == host_idx);
        if (host_we && !clash) begin
            mem_d[host_idx] = host_wdata;
        end
        if (ins_we) begin
            if (ins_hen[0]) mem_d[ins_idx][HALF_W-1:0]      = ins_wdata[HALF_W-1:0];
            if (ins_hen[1]) mem_d[ins_idx][DATA_W-1:HALF_W] = ins_wdata[DATA_W-1:HALF_W];
        end
        rd_d = host_rd_ok ? mem_q[host_idx] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '{default: '0};
            rd_q  <= '0;
        end else begin
            mem_q <= mem_d;
            rd_q  <= rd_d;
        end
    end

    AST_WRITE_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        ins_we |-> (ins_hen != 2'b00)); // R2

    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd_ok |=> (host_rdata == '0)); // R9

endmodule

// File: rtl/sgpr_exec_unit.sv
module sgpr_exec_unit
    import sgpr_pkg::*;
#(
    parameter int NUM_THREADS = 3,
    parameter int NUM_REGS    = 64,
    parameter int DATA_W      = 32,
    parameter int TID_W       = $clog2(NUM_THREADS),
    parameter int HADDR_W     = $clog2(NUM_THREADS) + $clog2(NUM_REGS) + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ins_valid,
    output logic               ins_ready,
    input  logic [INSN_W-1:0]  ins_word,
    input  logic [TID_W-1:0]   ins_tid,
    output logic               busy,
    output logic               err_pulse,
    input  logic               host_we,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata
);

    localparam int RSEL_W = $clog2(NUM_REGS);
    localparam int IDX_W  = TID_W + RSEL_W;
    localparam int HALF_W = DATA_W / 2;
    localparam logic [TID_W-1:0] MAX_TID = TID_W'(NUM_THREADS - 1);

    typedef struct packed {
        logic [LAT_W-1:0] cnt;
        sgpr_dec_t        dec;
        logic [TID_W-1:0] tid;
        logic             err;
    } state_t;

    state_t st_q, st_d;

    sgpr_dec_t         dec_in;
    logic              accept;
    logic              legal_in;
    logic              fin;
    logic [IDX_W-1:0]  ra_idx, rb_idx, wr_idx, h_idx;
    logic [DATA_W-1:0] ra_data, rb_data, opb, alu_res, wr_data;
    logic [1:0]        wr_hen;
    logic              wr_en;
    logic [TID_W-1:0]  h_tid;
    logic [RSEL_W-1:0] h_reg;
    logic              h_ok;
    logic              unused_bits;

    assign unused_bits = ^{host_addr[1:0], st_q.dec.lat};

    sgpr_decode u_decode (
        .word (ins_word),
        .dec  (dec_in)
    );

    sgpr_alu #(.DATA_W(DATA_W)) u_alu (
        .op  (st_q.dec.op),
        .opa (ra_data),
        .opb (opb),
        .res (alu_res)
    );

    sgpr_regfile #(
        .NUM_THREADS (NUM_THREADS),
        .NUM_REGS    (NUM_REGS),
        .DATA_W      (DATA_W),
        .IDX_W       (IDX_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ra_idx     (ra_idx),
        .rb_idx     (rb_idx),
        .ra_data    (ra_data),
        .rb_data    (rb_data),
        .ins_we     (wr_en),
        .ins_idx    (wr_idx),
        .ins_hen    (wr_hen),
        .ins_wdata  (wr_data),
        .host_we    (host_we && h_ok),
        .host_idx   (h_idx),
        .host_wdata (host_wdata),
        .host_rd_ok (h_ok),
        .host_rdata (host_rdata)
    );

    // Host address split: thread field above the register field, byte lane ignored
    always_comb begin
        h_tid = host_addr[HADDR_W-1 -: TID_W];
        h_reg = host_addr[RSEL_W+1:2];
        h_ok  = (h_tid <= MAX_TID);
        h_idx = {h_tid, h_reg};
    end

    // Retirement datapath, driven from the registered instruction
    always_comb begin
        fin    = (st_q.cnt == LAT_W'(1));
        ra_idx = {st_q.tid, st_q.dec.ra[RSEL_W-1:0]};
        rb_idx = {st_q.tid, st_q.dec.rb[RSEL_W-1:0]};
        opb    = st_q.dec.b_imm ? DATA_W'(st_q.dec.rb) : rb_data;
        wr_en  = 1'b0;
        wr_idx = {st_q.tid, st_q.dec.rd[RSEL_W-1:0]};
        wr_hen = 2'b11;
        wr_data = alu_res;
        case (st_q.dec.op)
            OP_HALF: begin
                wr_en   = fin;
                wr_idx  = {st_q.tid, st_q.dec.hidx[HIDX_W-1:1]};
                wr_hen  = st_q.dec.hidx[0] ? 2'b10 : 2'b01;
                wr_data = {2{HALF_W'(st_q.dec.imm)}};
            end
            OP_ADD, OP_MUL: wr_en = fin;
            default:        wr_en = 1'b0;
        endcase
    end

    // Sequencer next state
    always_comb begin
        st_d      = st_q;
        st_d.err  = 1'b0;
        ins_ready = (st_q.cnt <= LAT_W'(1));
        legal_in  = (dec_in.op != OP_BAD) && (ins_tid <= MAX_TID);
        accept    = ins_valid && ins_ready;
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - LAT_W'(1);
        end
        if (accept) begin
            if (legal_in) begin
                st_d.cnt = dec_in.lat;
                st_d.dec = dec_in;
                st_d.tid = ins_tid;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = (st_q.cnt != '0);
    assign err_pulse = st_q.err;

    AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ins_ready); // R7

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_ready && legal_in) |=> busy); // R7

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ins_ready) |=> busy); // R7

    AST_ERR_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> !busy); // R10

    AST_REJECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_ready && !legal_in) |=> err_pulse); // R10

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAT_SLOW); // R5

endmodule

// File: tb/sgpr_exec_unit_tb.sv
`timescale 1ns/1ps
module sgpr_exec_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ins_valid;
    logic        ins_ready;
    logic [31:0] ins_word;
    logic [1:0]  ins_tid;
    logic        busy;
    logic        err_pulse;
    logic        host_we;
    logic [9:0]  host_addr;
    logic [31:0] host_wdata;
    logic [31:0] host_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sgpr_exec_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ins_valid  (ins_valid),
        .ins_ready  (ins_ready),
        .ins_word   (ins_word),
        .ins_tid    (ins_tid),
        .busy       (busy),
        .err_pulse  (err_pulse),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    typedef struct packed {
        logic [1:0]  tid;
        logic [31:0] word;
        logic [1:0]  ctid;
        logic [5:0]  creg;
        logic [31:0] expv;
        logic [2:0]  lat;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{2'd0, 32'h58003081, 2'd0, 6'd3,  32'h00000002, 3'd3}, // add wrap, same group
        '{2'd0, 32'h58809FC8, 2'd0, 6'd9,  32'h1234AC0C, 3'd3}, // add const 63
        '{2'd0, 32'h5A006148, 2'd0, 6'd6,  32'h0001579A, 3'd4}, // mul mixed groups
        '{2'd0, 32'h5A007041, 2'd0, 6'd7,  32'hFFFE0001, 3'd4}, // mul truncated max
        '{2'd0, 32'h453ABC14, 2'd0, 6'd10, 32'h00003ABC, 3'd1}, // low half
        '{2'd0, 32'h45015515, 2'd0, 6'd10, 32'h01553ABC, 3'd1}, // high half
        '{2'd1, 32'h45200002, 2'd1, 6'd1,  32'h00002000, 3'd1}, // low half, thread 1
        '{2'd2, 32'h58801041, 2'd2, 6'd1,  32'h00000021, 3'd3}, // add const, thread 2
        '{2'd1, 32'h5A802141, 2'd1, 6'd2,  32'h0000A000, 3'd3}, // mul const
        '{2'd0, 32'h60000000, 2'd0, 6'd10, 32'h01553ABC, 3'd1}, // no-op
        '{2'd0, 32'h5800B248, 2'd0, 6'd11, 32'h246957D9, 3'd3}  // add same group 2
    };

    function automatic logic [9:0] haddr(input logic [1:0] t, input logic [5:0] r);
        return {t, r, 2'b00};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic host_write(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_read(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        @(negedge clk);
        d = host_rdata;
    endtask

    task automatic issue(input logic [1:0] t, input logic [31:0] w,
                         output int n, output logic e);
        @(negedge clk);
        ins_valid = 1'b1; ins_word = w; ins_tid = t;
        @(posedge clk);
        @(negedge clk);
        ins_valid = 1'b0;
        e = err_pulse;
        n = 0;
        while (busy && n < 20) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int          n;
        logic        e;

        rst_n = 1'b0; ins_valid = 1'b0; ins_word = '0; ins_tid = '0;
        host_we = 1'b0; host_addr = '0; host_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 ready", {31'd0, ins_ready}, 32'd1);
        check("R1 err", {31'd0, err_pulse}, 32'd0);
        host_read(haddr(2'd2, 6'd63), d);
        check("R1 register cleared", d, 32'h0);

        // R9: preload through host port
        host_write(haddr(2'd0, 6'd1), 32'hFFFFFFFF);
        host_write(haddr(2'd0, 6'd2), 32'h00000003);
        host_write(haddr(2'd0, 6'd5), 32'h00010002);
        host_write(haddr(2'd0, 6'd8), 32'h1234ABCD);
        host_write(haddr(2'd1, 6'd1), 32'h00000010);
        host_write(haddr(2'd2, 6'd1), 32'h00000020);
        host_read(haddr(2'd0, 6'd8), d);
        check("R9 host write/read", d, 32'h1234ABCD);

        // Vector table: R2 R3 R4 R5 R6 R8
        for (int i = 0; i < NVEC; i++) begin
            issue(VECS[i].tid, VECS[i].word, n, e);
            check($sformatf("R5/R6 latency vector %0d", i), 32'(n), 32'(VECS[i].lat));
            host_read(haddr(VECS[i].ctid, VECS[i].creg), d);
            check($sformatf("R2/R3/R4 result vector %0d", i), d, VECS[i].expv);
        end

        // R8: thread 1 write left thread 0 register 1 alone
        host_read(haddr(2'd0, 6'd1), d);
        check("R8 bank isolation", d, 32'hFFFFFFFF);

        // R9: byte lane bits ignored, thread field 3 dropped and reads zero
        host_read(haddr(2'd0, 6'd1) | 10'd3, d);
        check("R9 low address bits ignored", d, 32'hFFFFFFFF);
        host_write(10'h304, 32'h00000055);
        host_read(10'h304, d);
        check("R9 out-of-range reads zero", d, 32'h0);
        host_read(haddr(2'd0, 6'd1), d);
        check("R9 out-of-range write dropped", d, 32'hFFFFFFFF);

        // R10: unknown opcode
        issue(2'd0, 32'h77000000, n, e);
        check("R10 unknown opcode err", {31'd0, e}, 32'd1);
        check("R10 unknown opcode not busy", 32'(n), 32'd0);
        @(negedge clk);
        check("R10 err lasts one cycle", {31'd0, err_pulse}, 32'd0);

        // R10: half load with mode bit set changes nothing
        issue(2'd0, 32'h453ABC94, n, e);
        check("R10 mode bit err", {31'd0, e}, 32'd1);
        host_read(haddr(2'd0, 6'd10), d);
        check("R10 mode bit no write", d, 32'h01553ABC);

        // R10: thread tag 3
        issue(2'd3, 32'h45001114, n, e);
        check("R10 tag 3 err", {31'd0, e}, 32'd1);
        host_read(haddr(2'd0, 6'd10), d);
        check("R10 tag 3 no write", d, 32'h01553ABC);

        // R7: back-to-back no-ops keep busy high and ready high
        @(negedge clk);
        ins_valid = 1'b1; ins_word = 32'h60000000; ins_tid = 2'd0;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            @(negedge clk);
            check("R7 busy during stream", {31'd0, busy}, 32'd1);
            check("R7 ready during stream", {31'd0, ins_ready}, 32'd1);
        end
        ins_valid = 1'b0;
        @(negedge clk);
        check("R7 idle after stream", {31'd0, busy}, 32'd0);

        // R7: ready low inside a multi-cycle op
        @(negedge clk);
        ins_valid = 1'b1; ins_word = 32'h58003081; ins_tid = 2'd0;
        @(posedge clk);
        @(negedge clk);
        ins_valid = 1'b0;
        check("R7 ready low mid-op", {31'd0, ins_ready}, 32'd0);
        repeat (3) @(negedge clk);
        check("R7 ready after op", {31'd0, ins_ready}, 32'd1);

        // R11: host write on the retiring edge of a half load is dropped
        @(negedge clk);
        ins_valid = 1'b1; ins_word = 32'h45001128; ins_tid = 2'd0;
        @(posedge clk);
        @(negedge clk);
        ins_valid = 1'b0;
        host_we = 1'b1; host_addr = haddr(2'd0, 6'd20); host_wdata = 32'hDEADBEEF;
        @(posedge clk);
        @(negedge clk);
        host_we = 1'b0;
        host_read(haddr(2'd0, 6'd20), d);
        check("R11 instruction wins", d, 32'h00000011);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule